// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block collects eight interrupt lines and presents the most urgent unmasked one to a processor as a single request plus an 8-bit vector. Software reaches it over a byte-wide register bus with two locations: address 0 (command) and address 1 (data). After reset it stays silent until it receives a fixed four-word setup sequence. That sequence sets the vector base, the cascade arrangement and whether end-of-interrupt is automatic or issued by software.

Priority is fixed, and input 0 is the most urgent. A one-cycle acknowledge pulse takes the winning request and marks it as being in service. It then returns the vector one cycle later. Software ends service either by a specific end-of-interrupt command or, in automatic mode, implicitly. Two instances can be chained: the slave's request output drives one master input, and during acknowledge the master names that input on its cascade outputs so that the slave supplies the vector. If a request disappears before it is acknowledged, the block delivers the vector of input 7 and marks nothing as in service.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the mask reads 0xFF, `int_req` is low, and no request is raised until a command write with bit 4 set has been followed by three data writes. Writing that command again suppresses `int_req` until its three data writes are complete.
- R2: `vec_valid` rises for one cycle in the cycle after a taken acknowledge pulse. The vector is the base plus the input number, where the base is the upper five bits of the first data word after the setup command and the lower three bits are zero.
- R3: Once setup is complete, a data write loads the 8-bit mask and a data read returns it. A 1 in mask bit n stops input n from raising `int_req`, but the request still shows in the request register.
- R4: A command write of 0x0A selects the request register for command-port reads, and a command write of 0x0B selects the in-service register. The choice persists until it is changed, and the request register is selected after reset and after each setup command.
- R5: Input 0 has the highest priority. `int_req` is high only when an unmasked pending input has a lower number than every set in-service bit, and an acknowledge picks the lowest-numbered such input.
- R6: A taken acknowledge sets the in-service bit of the winner and clears its request bit. Without an acknowledge, no in-service bit is ever set.
- R7: A command write of 0x60 plus n (n in 0..7) clears in-service bit n and no other bit.
- R8: When bit 1 of the third setup data word is 1, each in-service bit set by an acknowledge is cleared one cycle later. When that bit is 0, in-service bits stay set until a specific end-of-interrupt.
- R9: If no input qualifies when the acknowledge is taken, the vector delivered is base plus 7 and the in-service register is unchanged. This holds even when input 7 is masked.
- R10: A request is latched on a rising edge of its input and is dropped while the input is low. An input held high produces only one request.
- R11: With `is_master` high, bit n of the second setup data word marks input n as having a slave. When such an input wins, the master sets its own in-service bit, drives `cas_en_out` high with the input number on `cas_sel_out` during the pulse, and gives no vector.
- R12: With `is_master` low, the block takes an acknowledge only while `cas_en_in` is high and `cas_sel_in` equals bits 2:0 of its second setup data word. It then supplies the vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| is_master | input | 1 | 1: chain head, 0: slave in a chain |
| bus_addr | input | 1 | 0 command location, 1 data location |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed location |
| irq_in | input | 8 | Interrupt lines, rising-edge sensitive |
| int_req | output | 1 | Request to the processor or to the master |
| int_ack | input | 1 | Acknowledge pulse, one cycle |
| cas_en_in | input | 1 | Master selects a slave (slave only) |
| cas_sel_in | input | 3 | Master input being served (slave only) |
| cas_en_out | output | 1 | This master hands the acknowledge to a slave |
| cas_sel_out | output | 3 | Input number handed to the slave |
| vec_out | output | 8 | Delivered vector |
| vec_valid | output | 1 | Vector strobe |

## Verification
The bench drives two patterns:
- **Single line held high through its acknowledge.** This separates edge latching from level latching.
- **Two lines raised in the same cycle.** This shows that the lower number wins.

Three further cases follow:
- **Raising a line while a more urgent one is in service.** This tells nesting apart from blocking.
- **A masked line and a line withdrawn before acknowledge.** These separate the masking path from the spurious path.

In a chained pair, a slave request is served while the master still holds its cascade input in service. This shows that the slave's end-of-interrupt alone does not reopen the master, and that the master's end-of-interrupt must follow it. A final re-setup in automatic mode shows the in-service bit clearing by itself.

// File: rtl/pic_pkg.sv
// Shared types for the priority interrupt controller.
// Assumes a byte-wide bus and at most 8 interrupt inputs.
package pic_pkg;
    // Setup sequence position: idle, or waiting for one of three data words
    typedef enum logic [1:0] {
        CFG_IDLE = 2'd0,
        CFG_BASE = 2'd1,
        CFG_CASC = 2'd2,
        CFG_MODE = 2'd3
    } cfg_state_e;
endpackage

// File: rtl/pic_cfg.sv
// Register-bus decoder and configuration store.
// Runs the ordered setup sequence and holds the vector base, cascade word,
// auto-EOI flag, mask and read selection. It also decodes specific EOI.
// Assumes one write strobe per access; reads are handled at the top.
module pic_cfg
    import pic_pkg::*;
#(
    parameter int DW   = 8,
    parameter int N_IN = 8,
    localparam int IDW = $clog2(N_IN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_addr,
    input  logic            bus_wr,
    input  logic [DW-1:0]   bus_wdata,
    output logic            ready,
    output logic [DW-1:0]   base_q,
    output logic [N_IN-1:0] casc_q,
    output logic            aeoi_q,
    output logic [N_IN-1:0] mask_q,
    output logic            rd_isr_q,
    output logic            setup_start,
    output logic            eoi_valid,
    output logic [IDW-1:0]  eoi_num
);
    cfg_state_e st_q;
    logic       cmd_wr, data_wr, cmd_rsel;

    // Classify each write as setup start, read selection or specific EOI
    always_comb begin
        cmd_wr      = bus_wr && !bus_addr;
        data_wr     = bus_wr && bus_addr;
        setup_start = cmd_wr && bus_wdata[4];
        cmd_rsel    = cmd_wr && !bus_wdata[4] && bus_wdata[3] && bus_wdata[1];
        eoi_valid   = cmd_wr && (bus_wdata[7:5] == 3'b011) && !bus_wdata[3];
        eoi_num     = bus_wdata[IDW-1:0];
    end

    // Step through the setup words and update the mask and read selection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= CFG_IDLE;
            ready    <= 1'b0;
            base_q   <= '0;
            casc_q   <= '0;
            aeoi_q   <= 1'b0;
            mask_q   <= '1;
            rd_isr_q <= 1'b0;
        end else if (setup_start) begin
            st_q     <= CFG_BASE;
            ready    <= 1'b0;
            rd_isr_q <= 1'b0;
        end else if (cmd_rsel) begin
            rd_isr_q <= bus_wdata[0];
        end else if (data_wr) begin
            unique case (st_q)
                CFG_BASE: begin
                    base_q <= {bus_wdata[DW-1:IDW], {IDW{1'b0}}};
                    st_q   <= CFG_CASC;
                end
                CFG_CASC: begin
                    casc_q <= bus_wdata[N_IN-1:0];
                    st_q   <= CFG_MODE;
                end
                CFG_MODE: begin
                    aeoi_q <= bus_wdata[1];
                    st_q   <= CFG_IDLE;
                    ready  <= 1'b1;
                end
                CFG_IDLE: begin
                    if (ready) mask_q <= bus_wdata[N_IN-1:0];
                end
            endcase
        end
    end
endmodule

// File: rtl/pic_resolve.sv
// Fixed-priority resolver: input 0 is most urgent. An unmasked request
// qualifies only if no in-service bit of equal or higher priority is set.
// Purely combinational; assumes request, service and mask are registered.
module pic_resolve #(
    parameter int N_IN = 8,
    localparam int IDW = $clog2(N_IN)
) (
    input  logic [N_IN-1:0] irr,
    input  logic [N_IN-1:0] isr,
    input  logic [N_IN-1:0] mask,
    output logic            any,
    output logic [IDW-1:0]  win
);
    // Scan from most urgent; the first set in-service bit blocks the rest
    always_comb begin
        logic blocked;
        blocked = 1'b0;
        any     = 1'b0;
        win     = '0;
        for (int i = 0; i < N_IN; i++) begin
            if (isr[i]) blocked = 1'b1;
            if (!blocked && !any && irr[i] && !mask[i]) begin
                any = 1'b1;
                win = IDW'(i);
            end
        end
    end
endmodule

// File: rtl/pic_service.sv
// Request and in-service registers with acknowledge and vector output.
// It latches rising edges, drops requests whose lines fall and takes the
// acknowledge, including spurious and cascade cases. It also applies
// specific EOI and auto-EOI. Assumes ack_take is a single-cycle pulse.
module pic_service #(
    parameter int DW   = 8,
    parameter int N_IN = 8,
    localparam int IDW = $clog2(N_IN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_IN-1:0] irq_in,
    input  logic            setup_start,
    input  logic            eoi_valid,
    input  logic [IDW-1:0]  eoi_num,
    input  logic            ack_take,
    input  logic            any,
    input  logic [IDW-1:0]  win,
    input  logic            win_cascaded,
    input  logic [DW-1:0]   base,
    input  logic            aeoi,
    output logic [N_IN-1:0] irr_q,
    output logic [N_IN-1:0] isr_q,
    output logic [DW-1:0]   vec_q,
    output logic            vec_valid_q
);
    localparam logic [IDW-1:0] SPUR_IN = IDW'(N_IN - 1);

    logic [N_IN-1:0] line_q, win_bit, pend_q;
    logic            take_real;

    // Decode the winner to a one-hot bit and note a non-spurious take
    always_comb begin
        win_bit   = '0;
        win_bit[win] = 1'b1;
        take_real = ack_take && any;
    end

    // Track lines for edge detection and keep requests only while high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
            irr_q  <= '0;
        end else begin
            line_q <= irq_in;
            if (setup_start) irr_q <= '0;
            else irr_q <= (irr_q | (irq_in & ~line_q)) & irq_in
                          & ~(take_real ? win_bit : '0);
        end
    end

    // Set, auto-clear and EOI-clear the in-service bits
    always_ff @(posedge clk) begin
        if (!rst_n || setup_start) begin
            isr_q  <= '0;
            pend_q <= '0;
        end else begin
            logic [N_IN-1:0] nxt;
            nxt = isr_q & ~pend_q;
            if (eoi_valid) nxt[eoi_num] = 1'b0;
            if (take_real) nxt = nxt | win_bit;
            isr_q  <= nxt;
            pend_q <= (take_real && aeoi) ? win_bit : '0;
        end
    end

    // Register the vector for the cycle after the acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q       <= '0;
            vec_valid_q <= 1'b0;
        end else begin
            vec_valid_q <= ack_take && !(any && win_cascaded);
            if (ack_take)
                vec_q <= base | DW'(any ? win : SPUR_IN);
        end
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
// Eight-input programmable priority interrupt controller, top level.
// Joins configuration, resolution and service. It gates requests and
// acknowledges on setup completion and routes the acknowledge to or from
// the cascade pins. Assumes int_ack is a one-cycle pulse shared by the
// master and its slave.
module prio_irq_ctrl #(
    parameter int DW   = 8,
    parameter int N_IN = 8,
    localparam int IDW = $clog2(N_IN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            is_master,
    input  logic            bus_addr,
    input  logic            bus_wr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [N_IN-1:0] irq_in,
    output logic            int_req,
    input  logic            int_ack,
    input  logic            cas_en_in,
    input  logic [IDW-1:0]  cas_sel_in,
    output logic            cas_en_out,
    output logic [IDW-1:0]  cas_sel_out,
    output logic [DW-1:0]   vec_out,
    output logic            vec_valid
);
    logic            ready, aeoi_q, rd_isr_q, setup_start, eoi_valid;
    logic            any, ack_take, win_cascaded;
    logic [IDW-1:0]  eoi_num, win;
    logic [DW-1:0]   base_q;
    logic [N_IN-1:0] casc_q, mask_q, irr_q, isr_q;

    pic_cfg #(.DW(DW), .N_IN(N_IN)) u_cfg (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .ready(ready), .base_q(base_q),
        .casc_q(casc_q), .aeoi_q(aeoi_q), .mask_q(mask_q),
        .rd_isr_q(rd_isr_q), .setup_start(setup_start),
        .eoi_valid(eoi_valid), .eoi_num(eoi_num)
    );

    pic_resolve #(.N_IN(N_IN)) u_res (
        .irr(irr_q), .isr(isr_q), .mask(mask_q), .any(any), .win(win)
    );

    // Decide whether this chip takes the pulse and whether it hands it on
    always_comb begin
        win_cascaded = is_master && casc_q[win];
        ack_take     = ready && int_ack &&
                       (is_master || (cas_en_in && cas_sel_in == casc_q[IDW-1:0]));
        cas_en_out   = ack_take && any && win_cascaded;
        cas_sel_out  = win;
        int_req      = ready && any;
    end

    pic_service #(.DW(DW), .N_IN(N_IN)) u_svc (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .setup_start(setup_start),
        .eoi_valid(eoi_valid), .eoi_num(eoi_num), .ack_take(ack_take),
        .any(any), .win(win), .win_cascaded(win_cascaded), .base(base_q),
        .aeoi(aeoi_q), .irr_q(irr_q), .isr_q(isr_q), .vec_q(vec_out),
        .vec_valid_q(vec_valid)
    );

    // Select read data: mask on data port, chosen register on command port
    always_comb begin
        if (bus_addr)      bus_rdata = DW'(mask_q);
        else if (rd_isr_q) bus_rdata = DW'(isr_q);
        else               bus_rdata = DW'(irr_q);
    end
endmodule

// File: rtl/pic_chk.sv
// Assertion checker for prio_irq_ctrl, attached by bind below.
// Observes ports plus the setup, mask and in-service state.
module pic_chk #(
    parameter int DW   = 8,
    parameter int N_IN = 8,
    localparam int IDW = $clog2(N_IN)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_addr,
    input logic            bus_wr,
    input logic [DW-1:0]   bus_wdata,
    input logic            int_req,
    input logic            int_ack,
    input logic            vec_valid,
    input logic            ready,
    input logic            aeoi,
    input logic [N_IN-1:0] isr,
    input logic [N_IN-1:0] mask
);
    // R1
    no_req_before_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !int_req);

    // R2
    vec_follows_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> $past(int_ack));

    // R3
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr && ready) |=> (mask == $past(bus_wdata[N_IN-1:0])));

    // R6
    isr_grows_only_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !int_ack |=> ($countones(isr) <= $countones($past(isr))));

    // R7
    eoi_clears_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_addr && bus_wdata[7:5] == 3'b011 && !bus_wdata[3] && !int_ack)
        |=> !isr[$past(bus_wdata[IDW-1:0])]);

    // R8
    auto_eoi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (aeoi && !int_ack) |=> (isr == '0));
endmodule

bind prio_irq_ctrl pic_chk #(.DW(DW), .N_IN(N_IN)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .int_req(int_req), .int_ack(int_ack),
    .vec_valid(vec_valid), .ready(ready), .aeoi(aeoi_q), .isr(isr_q),
    .mask(mask_q)
);

// File: tb/sim_prio_irq_ctrl.sv
// Bench: a master and a slave chained on master input 2.
module sim_prio_irq_ctrl;
    logic clk = 1'b0, rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic       addr = 1'b0, m_wr = 1'b0, s_wr = 1'b0, ack = 1'b0;
    logic [7:0] wdata = '0, m_lines = '0, s_lines = '0;
    logic [7:0] m_rdata, s_rdata, m_vec, s_vec, m_irq;
    logic       m_req, s_req, m_vv, s_vv, m_cen, s_cen_unused;
    logic [2:0] m_csel, s_csel_unused;

    int checks = 0, errors = 0;
    bit done = 0;

    always_comb m_irq = {m_lines[7:3], s_req, m_lines[1:0]};

    prio_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .is_master(1'b1), .bus_addr(addr),
        .bus_wr(m_wr), .bus_wdata(wdata), .bus_rdata(m_rdata),
        .irq_in(m_irq), .int_req(m_req), .int_ack(ack),
        .cas_en_in(1'b0), .cas_sel_in(3'd0), .cas_en_out(m_cen),
        .cas_sel_out(m_csel), .vec_out(m_vec), .vec_valid(m_vv)
    );

    prio_irq_ctrl u1 (
        .clk(clk), .rst_n(rst_n), .is_master(1'b0), .bus_addr(addr),
        .bus_wr(s_wr), .bus_wdata(wdata), .bus_rdata(s_rdata),
        .irq_in(s_lines), .int_req(s_req), .int_ack(ack),
        .cas_en_in(m_cen), .cas_sel_in(m_csel), .cas_en_out(s_cen_unused),
        .cas_sel_out(s_csel_unused), .vec_out(s_vec), .vec_valid(s_vv)
    );

    // Behavioural expectations
    function automatic int exp_vec(int base, int n);
        return base + n;
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(bit slave, bit a, logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; m_wr = !slave; s_wr = slave;
        @(negedge clk);
        m_wr = 1'b0; s_wr = 1'b0;
    endtask

    task automatic rd(bit slave, bit a, output logic [7:0] d);
        @(negedge clk);
        addr = a; #1;
        d = slave ? s_rdata : m_rdata;
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    // Pulse ack; return the vector seen in the next cycle
    task automatic pulse_ack(output logic mv, output logic sv, output logic [7:0] v);
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
        mv = m_vv; sv = s_vv; v = m_vv ? m_vec : s_vec;
    endtask

    task automatic setup(bit slave, logic [7:0] b, logic [7:0] c, logic [7:0] m);
        wr(slave, 0, 8'h11); wr(slave, 1, b); wr(slave, 1, c); wr(slave, 1, m);
    endtask

    initial begin
        repeat (10000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d, v;
        logic mv, sv;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);

        // R1 reset state
        rd(0, 1, d); chk("R1 mask after reset", d, 8'hFF);
        chk("R1 int_req after reset", m_req, 0);
        rd(0, 0, d); chk("R4 default read is IRR", d, 8'h00);
        m_lines[5] = 1'b1; wait_cyc(2);
        chk("R1 no request before setup", m_req, 0);
        m_lines[5] = 1'b0; wait_cyc(1);

        setup(0, 8'h20, 8'h04, 8'h01);
        setup(1, 8'h28, 8'h02, 8'h01);
        wr(0, 1, 8'h00);
        rd(0, 1, d); chk("R3 mask readback", d, 8'h00);

        // Held-high line, nesting and blocking
        m_lines[5] = 1'b1; wait_cyc(2);
        chk("R5 request raised", m_req, 1);
        pulse_ack(mv, sv, v);
        chk("R2 vector input 5", v, exp_vec(8'h20, 5));
        chk("R12 slave silent on master input", sv, 0);
        rd(0, 0, d); chk("R10 held line requests once", d, 8'h00);
        wr(0, 0, 8'h0B);
        rd(0, 0, d); chk("R6 ISR after ack", d, 8'h20);
        m_lines[6] = 1'b1; wait_cyc(2);
        chk("R5 lower priority blocked", m_req, 0);
        m_lines[3] = 1'b1; wait_cyc(2);
        chk("R5 higher priority nests", m_req, 1);
        pulse_ack(mv, sv, v);
        chk("R2 vector input 3", v, exp_vec(8'h20, 3));
        rd(0, 0, d); chk("R4 ISR select persists", d, 8'h28);
        wr(0, 0, 8'h63);
        rd(0, 0, d); chk("R7 EOI clears bit 3 only", d, 8'h20);
        chk("R5 still blocked by 5", m_req, 0);
        wr(0, 0, 8'h65); wait_cyc(1);
        chk("R5 released after EOI", m_req, 1);
        pulse_ack(mv, sv, v);
        chk("R2 vector input 6", v, exp_vec(8'h20, 6));
        wr(0, 0, 8'h66);
        m_lines = '0;
        wr(0, 0, 8'h0A); wait_cyc(1);

        // Masking
        wr(0, 1, 8'h10);
        m_lines[4] = 1'b1; wait_cyc(2);
        chk("R3 masked input no request", m_req, 0);
        rd(0, 0, d); chk("R3 masked request visible in IRR", d, 8'h10);
        wr(0, 1, 8'h00); wait_cyc(1);
        chk("R3 unmask raises request", m_req, 1);
        pulse_ack(mv, sv, v);
        chk("R2 vector input 4", v, exp_vec(8'h20, 4));
        wr(0, 0, 8'h64);
        m_lines = '0; wait_cyc(1);

        // Spurious
        m_lines[1] = 1'b1; wait_cyc(2);
        chk("R10 edge latched", m_req, 1);
        m_lines[1] = 1'b0; wait_cyc(2);
        chk("R10 request dropped with line", m_req, 0);
        pulse_ack(mv, sv, v);
        chk("R9 spurious vector", v, exp_vec(8'h20, 7));
        chk("R9 spurious strobe", mv, 1);
        wr(0, 0, 8'h0B);
        rd(0, 0, d); chk("R9 ISR untouched", d, 8'h00);

        // Simultaneous requests
        m_lines[6] = 1'b1; m_lines[1] = 1'b1; wait_cyc(2);
        pulse_ack(mv, sv, v);
        chk("R5 lower number wins", v, exp_vec(8'h20, 1));
        wr(0, 0, 8'h61);
        pulse_ack(mv, sv, v);
        chk("R5 remaining input served", v, exp_vec(8'h20, 6));
        wr(0, 0, 8'h66);
        m_lines = '0; wait_cyc(1);

        // Cascade
        wr(1, 1, 8'h00);
        wr(1, 0, 8'h0B);
        s_lines[3] = 1'b1; wait_cyc(3);
        chk("R11 slave request reaches master", m_req, 1);
        pulse_ack(mv, sv, v);
        chk("R11 master gives no vector", mv, 0);
        chk("R12 slave strobe", sv, 1);
        chk("R12 slave vector", v, exp_vec(8'h28, 3));
        rd(0, 0, d); chk("R11 master ISR input 2", d, 8'h04);
        rd(1, 0, d); chk("R6 slave ISR", d, 8'h08);
        wr(1, 0, 8'h63);
        rd(1, 0, d); chk("R7 slave EOI", d, 8'h00);
        rd(0, 0, d); chk("R7 master still in service", d, 8'h04);
        s_lines[5] = 1'b1; wait_cyc(3);
        chk("R5 master blocks cascade until its EOI", m_req, 0);
        wr(0, 0, 8'h62); wait_cyc(1);
        chk("R5 master EOI reopens cascade", m_req, 1);
        pulse_ack(mv, sv, v);
        chk("R12 second slave vector", v, exp_vec(8'h28, 5));
        wr(1, 0, 8'h65); wr(0, 0, 8'h62);
        rd(0, 0, d); chk("R7 master clear", d, 8'h00);
        s_lines = '0; wait_cyc(2);

        // Auto-EOI re-setup
        wr(0, 0, 8'h11);
        m_lines[0] = 1'b1; wait_cyc(2);
        chk("R1 suppressed during setup", m_req, 0);
        wr(0, 1, 8'h20); wr(0, 1, 8'h04); wr(0, 1, 8'h03);
        wait_cyc(1);
        chk("R1 request after setup", m_req, 1);
        rd(0, 1, d); chk("R3 mask kept over setup", d, 8'h00);
        pulse_ack(mv, sv, v);
        chk("R2 vector input 0", v, exp_vec(8'h20, 0));
        wr(0, 0, 8'h0B);
        rd(0, 0, d); chk("R8 auto EOI clears ISR", d, 8'h00);
        m_lines = '0;

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule